// File: doc/BRIEF.md
# CFI and ID Query Responder

This block forms the read data returned while a parallel flash bank is in identification mode or in Common Flash Interface query mode. The bank consists of one or more identical flash devices placed side by side on the data bus. The command sequencer selects the mode. The bus supplies a byte offset and an access size. The responder turns the offset into a query index, fetches a byte from the query table or picks one of the two identification codes, and copies that answer into every device lane of the bank.

The geometry is fixed at elaboration. There are three widths, each 1, 2 or 4 bytes: the width of the bank, the width at which each device is used, and the widest mode the device supports. A device used narrower than its widest mode still expects query addresses laid out for the widest mode, so the offset is scaled by the width difference. An access wider than the bank is built from several bank-width lookups at consecutive bank-width steps. The answer is registered and appears one clock after the request strobe.

Top module: `cfi_id_responder`

## Requirements
- R1: When `req_valid` is high at a rising edge, `rsp_valid` is high after that edge and `rsp_data` carries the answer to that request. When `req_valid` is low at an edge, `rsp_valid` is low after it and `rsp_data` keeps its previous value.
- R2: The query index of a lookup is its byte offset (modulo 2^OFS_W) shifted right by log2(BANK_W) + log2(MAX_W) - log2(DEV_W).
- R3: In CFI mode (`req_mode` = 1), an index of 0x52 or more returns a zero byte.
- R4: The query table returns 0x51, 0x52 and 0x59 ("QRY") at indices 0x10, 0x11 and 0x12, returns 0x01 at 0x13 and 0x00 at 0x14, and returns zero at every other index below 0x52.
- R5: In CFI mode, when DEV_W differs from MAX_W and DEV_W is not 1, every byte of the answer is zero.
- R6: In ID mode (`req_mode` = 0), only bits [7:0] of the index are decoded. Index 0 returns MFR_ID, index 1 returns DEV_ID, and every other value returns zero. Each code is truncated or zero-extended to DEV_W bytes.
- R7: Every DEV_W-byte slot of a bank-width word carries the same per-device answer. When DEV_W equals MAX_W, a CFI answer has its table byte in the lowest byte of the slot and zeros in the slot's other bytes. When DEV_W is 1 and smaller than MAX_W, every byte lane carries the table byte.
- R8: For an access of more than BANK_W bytes, lookup k (k = 0, 1, ...) uses offset + k*BANK_W and fills `rsp_data` bits [k*BANK_W*8 +: BANK_W*8].
- R9: `req_size` encodes the access as 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Bytes of `rsp_data` above the access size are zero.
- R10: While `rst_n` is low, `rsp_valid` and `rsp_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per read |
| req_mode | input | 1 | 0 = identification read, 1 = CFI query read |
| req_size | input | 2 | Access size code (R9) |
| req_offset | input | OFS_W | Bus byte offset of the access |
| rsp_valid | output | 1 | Answer present on `rsp_data` |
| rsp_data | output | 32 | Answer, lowest offset in the lowest bits |

## Verification
Each answer goes through exactly one register, so it is due at the first rising edge after the strobe. The bench changes inputs on falling edges. It samples `rsp_valid` and `rsp_data` on the following falling edge, half a period after the capturing edge. The bench then changes the offset while the strobe is low and samples again one falling edge later, which checks that `rsp_valid` has dropped and that the data is unchanged. Three bank geometries run side by side on the same stimulus: a narrow-mode bank, a native-width bank and an unsupported mismatch. Expected words are built byte by byte from the requirements.

// File: rtl/cfi_resp_pkg.sv
package cfi_resp_pkg;

  localparam int CFI_TBL_LEN = 'h52;

  typedef enum logic {
    QRY_ID  = 1'b0,
    QRY_CFI = 1'b1
  } qry_mode_e;

  // Fixed query table; entries not listed read as zero.
  function automatic logic [7:0] cfi_tbl_byte(input logic [6:0] i);
    case (i)
      7'h10:   return 8'h51;
      7'h11:   return 8'h52;
      7'h12:   return 8'h59;
      7'h13:   return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int unsigned size_bytes(input logic [1:0] s);
    case (s)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] s);
    case (s)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int unsigned log2w(input int unsigned w);
    return (w >= 4) ? 2 : ((w == 2) ? 1 : 0);
  endfunction

endpackage

// File: rtl/cfi_index_norm.sv
module cfi_index_norm #(
  parameter int OFS_W  = 12,
  parameter int BANK_W = 2,
  parameter int SHIFT  = 2,
  parameter int CHUNK  = 0
) (
  input  logic [OFS_W-1:0] offset,
  output logic [OFS_W-1:0] idx
);
  localparam logic [OFS_W-1:0] STEP = OFS_W'(CHUNK * BANK_W);

  logic [OFS_W-1:0] chunk_ofs;

  assign chunk_ofs = offset + STEP;
  assign idx       = chunk_ofs >> SHIFT;
endmodule

// File: rtl/cfi_device_word.sv
module cfi_device_word
  import cfi_resp_pkg::*;
#(
  parameter int          OFS_W  = 12,
  parameter int          BANK_W = 2,
  parameter int          DEV_W  = 1,
  parameter int          MAX_W  = 2,
  parameter logic [15:0] MFR_ID = 16'h0089,
  parameter logic [15:0] DEV_ID = 16'h0018
) (
  input  logic [OFS_W-1:0]   idx,
  input  logic               mode,
  output logic [DEV_W*8-1:0] dev_lane,
  output logic               cfi_oob
);
  localparam int                DEVB     = DEV_W * 8;
  localparam logic [DEVB-1:0] MFR_LANE = DEVB'(MFR_ID);
  localparam logic [DEVB-1:0] DEV_LANE = DEVB'(DEV_ID);

  logic [7:0]      tbyte;
  logic [DEVB-1:0] cfi_lane;
  logic [DEVB-1:0] id_lane;

  assign cfi_oob = (32'(idx) >= 32'(CFI_TBL_LEN));
  assign tbyte   = cfi_oob ? 8'h00 : cfi_tbl_byte(idx[6:0]);

  generate
    if (DEV_W == MAX_W) begin : g_native
      assign cfi_lane = DEVB'(tbyte);
    end else if (DEV_W == 1 && BANK_W <= 4) begin : g_narrow
      // Byte mode of a wider part: the byte repeats over the wide width,
      // and the one-byte lane keeps a single copy.
      assign cfi_lane = tbyte;
    end else begin : g_unsup
      assign cfi_lane = '0;
    end
  endgenerate

  always_comb begin
    case (idx[7:0])
      8'd0:    id_lane = MFR_LANE;
      8'd1:    id_lane = DEV_LANE;
      default: id_lane = '0;
    endcase
  end

  assign dev_lane = (qry_mode_e'(mode) == QRY_CFI) ? cfi_lane : id_lane;
endmodule

// File: rtl/cfi_bank_replicate.sv
module cfi_bank_replicate #(
  parameter int BANK_W = 2,
  parameter int DEV_W  = 1
) (
  input  logic [DEV_W*8-1:0]  dev_lane,
  output logic [BANK_W*8-1:0] bank_word
);
  localparam int DEVB  = DEV_W * 8;
  localparam int SLOTS = BANK_W / DEV_W;

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign bank_word[s*DEVB +: DEVB] = dev_lane;
    end
  endgenerate
endmodule

// File: rtl/cfi_id_responder.sv
module cfi_id_responder
  import cfi_resp_pkg::*;
#(
  parameter int          BANK_W = 2,
  parameter int          DEV_W  = 1,
  parameter int          MAX_W  = 2,
  parameter int          OFS_W  = 12,
  parameter logic [15:0] MFR_ID = 16'h0089,
  parameter logic [15:0] DEV_ID = 16'h0018
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_mode,
  input  logic [1:0]       req_size,
  input  logic [OFS_W-1:0] req_offset,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data
);
  localparam int DATA_W = 32;
  localparam int BANKB  = BANK_W * 8;
  localparam int DEVB   = DEV_W * 8;
  localparam int NCHUNK = DATA_W / BANKB;
  localparam int SHIFT  = int'(log2w(BANK_W) + log2w(MAX_W)) - int'(log2w(DEV_W));

  logic [NCHUNK-1:0][OFS_W-1:0] chunk_idx;
  logic [NCHUNK-1:0]            chunk_oob;
  logic [NCHUNK-1:0][DEVB-1:0]  chunk_lane;
  logic [DATA_W-1:0]            wide_word;
  logic [DATA_W-1:0]            next_data;

  // Named taps for the checker.
  logic [OFS_W-1:0] lookup_idx0;
  logic             lookup_oob0;

  generate
    for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
      cfi_index_norm #(
        .OFS_W (OFS_W),
        .BANK_W(BANK_W),
        .SHIFT (SHIFT),
        .CHUNK (k)
      ) u_norm (
        .offset(req_offset),
        .idx   (chunk_idx[k])
      );

      cfi_device_word #(
        .OFS_W (OFS_W),
        .BANK_W(BANK_W),
        .DEV_W (DEV_W),
        .MAX_W (MAX_W),
        .MFR_ID(MFR_ID),
        .DEV_ID(DEV_ID)
      ) u_dev (
        .idx     (chunk_idx[k]),
        .mode    (req_mode),
        .dev_lane(chunk_lane[k]),
        .cfi_oob (chunk_oob[k])
      );

      cfi_bank_replicate #(
        .BANK_W(BANK_W),
        .DEV_W (DEV_W)
      ) u_rep (
        .dev_lane (chunk_lane[k]),
        .bank_word(wide_word[k*BANKB +: BANKB])
      );
    end
  endgenerate

  assign lookup_idx0 = chunk_idx[0];
  assign lookup_oob0 = chunk_oob[0];
  assign next_data   = wide_word & size_mask(req_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_data <= next_data;
      end
    end
  end
endmodule

// File: rtl/cfi_id_responder_chk.sv
module cfi_id_responder_chk
  import cfi_resp_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int DEV_W  = 1,
  parameter int OFS_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_mode,
  input logic [1:0]       req_size,
  input logic [OFS_W-1:0] idx0,
  input logic             oob0,
  input logic             rsp_valid,
  input logic [31:0]      rsp_data
);
  localparam int DEVB = DEV_W * 8;

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_data_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_data));

  p_cfi_oob_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode && oob0) |=> (rsp_data[7:0] == 8'h00));

  p_id_other_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_mode && (idx0[7:0] > 8'd1)) |=> (rsp_data[7:0] == 8'h00));

  p_byte_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd0) |=> (rsp_data[31:8] == 24'h0));

  generate
    if (DEV_W < BANK_W) begin : g_lane
      p_lane_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && size_bytes(req_size) >= BANK_W)
          |=> (rsp_data[DEVB +: DEVB] == rsp_data[DEVB-1:0]));
    end
  endgenerate
endmodule

bind cfi_id_responder cfi_id_responder_chk #(
  .BANK_W(BANK_W),
  .DEV_W (DEV_W),
  .OFS_W (OFS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_mode (req_mode),
  .req_size (req_size),
  .idx0     (lookup_idx0),
  .oob0     (lookup_oob0),
  .rsp_valid(rsp_valid),
  .rsp_data (rsp_data)
);

// File: tb/sim_cfi_id_responder.sv
`timescale 1ns/1ps
module sim_cfi_id_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_mode = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [11:0] req_offset = 12'h0;
  logic        v0, v1, v2;
  logic [31:0] d0, d1, d2;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // Narrow-mode bank: two byte lanes of parts that are 16 bits at most.
  cfi_id_responder #(.BANK_W(2), .DEV_W(1), .MAX_W(2), .OFS_W(12),
    .MFR_ID(16'h0089), .DEV_ID(16'h0018)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_size(req_size), .req_offset(req_offset), .rsp_valid(v0), .rsp_data(d0));
  // Native-width bank: two 16-bit parts.
  cfi_id_responder #(.BANK_W(4), .DEV_W(2), .MAX_W(2), .OFS_W(12),
    .MFR_ID(16'h00B0), .DEV_ID(16'h22D7)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_size(req_size), .req_offset(req_offset), .rsp_valid(v1), .rsp_data(d1));
  // Unsupported mismatch: 32-bit parts run at 16 bits.
  cfi_id_responder #(.BANK_W(4), .DEV_W(2), .MAX_W(4), .OFS_W(12),
    .MFR_ID(16'h0001), .DEV_ID(16'h227E)) u2 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_size(req_size), .req_offset(req_offset), .rsp_valid(v2), .rsp_data(d2));

  function automatic int lg(input int w);
    if (w == 1) return 0;
    if (w == 2) return 1;
    return 2;
  endfunction

  function automatic int tbl(input int i);
    case (i)
      16: return 'h51;   // Q
      17: return 'h52;   // R
      18: return 'h59;   // Y
      19: return 'h01;
      default: return 0; // includes 0x14
    endcase
  endfunction

  // Expected word, built byte by byte from the requirements.
  function automatic logic [31:0] expect_word(input int bank, input int dev, input int mx,
                                              input int mfr, input int dvc, input int mode,
                                              input int size, input int off);
    logic [31:0] w = '0;
    int acc = (size == 0) ? 1 : ((size == 1) ? 2 : 4);
    int sh  = lg(bank) + lg(mx) - lg(dev);
    for (int j = 0; j < 4; j++) begin
      int b = 0;
      if (j < acc) begin
        int k   = j / bank;
        int o   = (off + k * bank) & 'hFFF;
        int idx = o >> sh;
        int d   = (j % bank) % dev;
        if (mode == 1) begin
          if (idx >= 'h52) b = 0;
          else if (dev != mx && dev != 1) b = 0;
          else if (dev == mx) b = (d == 0) ? tbl(idx) : 0;
          else b = tbl(idx);
        end else begin
          int lo   = idx & 'hFF;
          int code = (lo == 0) ? mfr : ((lo == 1) ? dvc : 0);
          b = (d < 2) ? ((code >> (8 * d)) & 'hFF) : 0;
        end
      end
      w[j*8 +: 8] = 8'(b);
    end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_req(input int mode, input int size, input int off);
    string t0, t1, t2, st;
    int idx0;
    logic [31:0] e0, e1, e2, held;
    e0 = expect_word(2, 1, 2, 'h0089, 'h0018, mode, size, off);
    e1 = expect_word(4, 2, 2, 'h00B0, 'h22D7, mode, size, off);
    e2 = expect_word(4, 2, 4, 'h0001, 'h227E, mode, size, off);
    idx0 = off >> 2;
    st = (size == 0) ? "R9" : ((size == 1) ? "R2" : "R8");
    if (mode == 1) t0 = (idx0 >= 'h52) ? "R3" : ((idx0 >= 'h10 && idx0 <= 'h14) ? "R4" : "R2");
    else t0 = "R6";
    t1 = "R7";
    t2 = (mode == 1) ? "R5" : "R6";
    @(negedge clk);
    req_valid  = 1'b1;
    req_mode   = mode[0];
    req_size   = size[1:0];
    req_offset = off[11:0];
    @(negedge clk);
    req_valid  = 1'b0;
    req_offset = ~req_offset;
    chk($sformatf("R1 valid off=%03h", off), {31'b0, v0}, 32'd1);
    chk($sformatf("%s %s u0 m=%0d s=%0d off=%03h", t0, st, mode, size, off), d0, e0);
    chk($sformatf("%s %s u1 m=%0d s=%0d off=%03h", t1, st, mode, size, off), d1, e1);
    chk($sformatf("%s %s u2 m=%0d s=%0d off=%03h", t2, st, mode, size, off), d2, e2);
    held = d0;
    @(negedge clk);
    chk("R1 idle valid", {31'b0, v0}, 32'd0);
    chk("R1 idle hold", d0, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R10: a strobe during reset must not leave a mark.
    req_valid = 1'b1;
    req_mode  = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {31'b0, v0}, 32'd0);
    chk("R10 reset data", d0, 32'd0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release valid", {31'b0, v0}, 32'd0);
    chk("R10 after release data", d0, 32'd0);

    for (int mode = 0; mode < 2; mode++)
      for (int size = 0; size < 4; size++)
        for (int off = 0; off < 'h180; off++)
          do_req(mode, size, off);

    // R8 wrap of the stepped offset at the top of the space; R6 high index bits.
    for (int mode = 0; mode < 2; mode++)
      for (int off = 'hFF0; off < 'h1000; off++)
        do_req(mode, 2, off);
    do_req(0, 2, 'h400);
    do_req(0, 2, 'h404);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule